// File: doc/BRIEF.md
# Native-Mode FM Register Decoder

This block sits behind the host port of an FM synthesizer with 18 channels of four operators each. It takes register writes in the synthesizer's extended native mode and routes each one to the correct store. The stores are a byte-wide parameter store per operator, key-on and four-operator flags per channel, and a small set of global controls: two timer reload values, timer enables and masks, keyscale mode, a rhythm byte and a test register. The sound engines take the decoded state from the output ports.

The address space is 11 bits wide and flat. The operator index increases linearly, with eight byte registers per operator. A block of key-on bytes follows it. The two highest channels each have a key-on register split into two halves. Global registers are matched after address bit 9 is masked off. A combinational read port packs the same state back into bytes. Each write to an operator's delay field compares the new value with the stored one and records whether the delay went up or down. The envelope logic uses this record.

Top module: `synth_reg_decoder`

## Requirements
- R1: Only address bits 10:0 count. An address A below 576 selects operator byte A. That is channel A[10:5], operator A[4:3], register A[2:0], and the flat operator index is A[10:3]. A write stores the full byte, and a read of the same address returns it.
- R2: After reset every stored field is zero, with one exception. Register 6 of every operator resets to 0x30, so both output-enable bits are set.
- R3: A write to address 576+c, with c from 0 to 15, sets key_on[c] from data bit 0 and four_op[c] from data bit 1. A read returns {6'b0, four_op, key_on} for that channel.
- R4: Addresses 592 to 595 serve channels 16 and 17. Address bit 1 picks the channel. Address bit 0 clear selects key_on/four_op of that channel. Address bit 0 set selects the second half (key_on_b/four_op_b at index bit 1). Bits 0 and 1 of the data and read-back are laid out as in R3.
- R5: A write to operator register 5 compares data bits 7:5 (delay) with the stored delay. delay_up[op] becomes 1 exactly when the new value is larger. delay_dn[op] becomes 1 exactly when it is smaller. Both flags hold until the next register-5 write to that operator and are never set together.
- R6: Above address 595, globals are matched on A & 0x5FF. 0x402 and 0x403 hold the timer reload bytes. 0x404 stores the enables from bits 1:0 and the masks from bits 6:5, and reads back only those bits in place. A write to 0x404 with bit 7 set pulses flag_clr for one cycle.
- R7: A write to 0x504 sets four_op[2:0] from data bits 2:0 and four_op[11:9] from bits 5:3. A read of 0x504 returns the same packing.
- R8: Bit 6 of 0x408 is the keyscale mode and reads back on bit 6. 0x4BD stores and returns a full rhythm byte.
- R9: In test register 0x501, a write with bit 0 or bit 5 set sets the halt flag, which reads back on bit 5. Written bit 5 is also kept separately and reads back on bit 0. Bits 1 to 4, 6 and 7 read back in place. test_o carries the read-back form.
- R10: A read of 0x505 returns new_mode_i on bit 0 and native_mode_i on bit 7, with all other bits zero. Writes to 0x505 change nothing.
- R11: Writes to any other address change no state, and reads from them return 0.
- R12: rd_data is combinational from the stored state. A write becomes visible in the read data and in the outputs after the clock edge that takes it. In the cycle of the write, the read shows the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | Write address (bits 10:0 used) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 16 | Read address (bits 10:0 used) |
| rd_data | output | 8 | Packed read data |
| new_mode_i | input | 1 | New-mode flag shown at 0x505 bit 0 |
| native_mode_i | input | 1 | Native-mode flag shown at 0x505 bit 7 |
| key_on | output | 18 | Per-channel key-on |
| four_op | output | 18 | Per-channel four-operator enable |
| key_on_b | output | 2 | Second-half key-on of channels 16 and 17 |
| four_op_b | output | 2 | Second-half four-op flag of channels 16 and 17 |
| tmr_load_a | output | 8 | Timer A reload |
| tmr_load_b | output | 8 | Timer B reload |
| tmr_en | output | 2 | Timer enables |
| tmr_mask | output | 2 | Timer masks |
| flag_clr | output | 1 | One-cycle pulse to clear overflow and IRQ flags |
| ks_mode | output | 1 | Keyscale mode |
| rhythm | output | 8 | Rhythm control byte |
| test_o | output | 8 | Test register in read-back form |
| delay_up | output | 72 | Per-operator delay-increased flag |
| delay_dn | output | 72 | Per-operator delay-decreased flag |

## Verification
The bench builds the block with its default parameters: 18 channels, 4 operators and 8 registers, which gives the full 11-bit map. With these values every boundary is in reach: the last operator byte at 575, the 576/592/596 edges and the alias of globals through address bit 9 (for example 0x602 reaching the timer A reload). Random upper address bits test the masking. A behavioural model is compared with every output on every cycle, through directed sequences and then random traffic that concentrates on these edges.

// File: rtl/synth_reg_decoder.sv
module synth_reg_decoder #(
  parameter int NCH  = 18,
  parameter int NOP  = 4,
  parameter int NREG = 8,
  parameter int AW   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [15:0]          wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [15:0]          rd_addr,
  output logic [7:0]           rd_data,
  input  logic                 new_mode_i,
  input  logic                 native_mode_i,
  output logic [NCH-1:0]       key_on,
  output logic [NCH-1:0]       four_op,
  output logic [1:0]           key_on_b,
  output logic [1:0]           four_op_b,
  output logic [7:0]           tmr_load_a,
  output logic [7:0]           tmr_load_b,
  output logic [1:0]           tmr_en,
  output logic [1:0]           tmr_mask,
  output logic                 flag_clr,
  output logic                 ks_mode,
  output logic [7:0]           rhythm,
  output logic [7:0]           test_o,
  output logic [NCH*NOP-1:0]   delay_up,
  output logic [NCH*NOP-1:0]   delay_dn
);
  localparam int NSLOT = NCH * NOP;
  localparam int OPS   = NSLOT * NREG;
  localparam int MW    = $clog2(OPS);
  localparam int RW    = $clog2(NREG);
  localparam int CW    = $clog2(NCH);
  localparam logic [AW-1:0] KEY_LO = AW'(OPS);
  localparam logic [AW-1:0] SPL_LO = AW'(OPS + NCH - 2);
  localparam logic [AW-1:0] SPL_HI = AW'(OPS + NCH + 2);
  localparam logic [AW-1:0] GMASK  = AW'('h5FF);
  localparam logic [AW-1:0] G_TA = AW'('h402), G_TB = AW'('h403), G_TC = AW'('h404);
  localparam logic [AW-1:0] G_CF = AW'('h408), G_RH = AW'('h4BD), G_TS = AW'('h501);
  localparam logic [AW-1:0] G_4O = AW'('h504), G_MD = AW'('h505);

  logic [7:0] opm [OPS];
  logic [AW-1:0] wa, ra, wg, rg, wk, rk;
  logic wop, wkey, wspl, wglb, rop, rkey, rspl;
  logic [2:0] old_dly;
  logic [MW-RW-1:0] wslot;
  logic tst_halt, tst_w5;
  logic [3:0] tst_mid;
  logic [1:0] tst_hi;

  assign wa   = wr_addr[AW-1:0];
  assign ra   = rd_addr[AW-1:0];
  assign wg   = wa & GMASK;
  assign rg   = ra & GMASK;
  assign wk   = wa - KEY_LO;
  assign rk   = ra - KEY_LO;
  assign wop  = wa < KEY_LO;
  assign wkey = !wop && wa < SPL_LO;
  assign wspl = wa >= SPL_LO && wa < SPL_HI;
  assign wglb = wa >= SPL_HI;
  assign rop  = ra < KEY_LO;
  assign rkey = !rop && ra < SPL_LO;
  assign rspl = ra >= SPL_LO && ra < SPL_HI;
  assign wslot   = wa[MW-1:RW];
  assign old_dly = opm[wa[MW-1:0]][7:5];
  assign test_o  = {tst_hi, tst_halt, tst_mid, tst_w5};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < OPS; i++) opm[i] <= (i % NREG == 6) ? 8'h30 : 8'h00;
      key_on <= '0; four_op <= '0; key_on_b <= '0; four_op_b <= '0;
      tmr_load_a <= '0; tmr_load_b <= '0; tmr_en <= '0; tmr_mask <= '0;
      flag_clr <= 1'b0; ks_mode <= 1'b0; rhythm <= '0;
      tst_halt <= 1'b0; tst_w5 <= 1'b0; tst_mid <= '0; tst_hi <= '0;
      delay_up <= '0; delay_dn <= '0;
    end else begin
      flag_clr <= 1'b0;
      if (wr_en) begin
        if (wop) begin
          opm[wa[MW-1:0]] <= wr_data;
          if (wa[RW-1:0] == RW'(5)) begin
            delay_up[wslot] <= wr_data[7:5] > old_dly;
            delay_dn[wslot] <= wr_data[7:5] < old_dly;
          end
        end else if (wkey) begin
          key_on[wk[CW-1:0]]  <= wr_data[0];
          four_op[wk[CW-1:0]] <= wr_data[1];
        end else if (wspl) begin
          if (wa[0]) begin
            key_on_b[wa[1]]  <= wr_data[0];
            four_op_b[wa[1]] <= wr_data[1];
          end else begin
            key_on[CW'(NCH-2) + CW'(wa[1])]  <= wr_data[0];
            four_op[CW'(NCH-2) + CW'(wa[1])] <= wr_data[1];
          end
        end else begin
          case (wg)
            G_TA: tmr_load_a <= wr_data;
            G_TB: tmr_load_b <= wr_data;
            G_TC: begin
              tmr_en   <= wr_data[1:0];
              tmr_mask <= wr_data[6:5];
              flag_clr <= wr_data[7];
            end
            G_CF: ks_mode <= wr_data[6];
            G_RH: rhythm  <= wr_data;
            G_TS: begin
              tst_halt <= wr_data[0] | wr_data[5];
              tst_w5   <= wr_data[5];
              tst_mid  <= wr_data[4:1];
              tst_hi   <= wr_data[7:6];
            end
            G_4O: begin
              four_op[2:0]  <= wr_data[2:0];
              four_op[11:9] <= wr_data[5:3];
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rop) rd_data = opm[ra[MW-1:0]];
    else if (rkey) rd_data = {6'b0, four_op[rk[CW-1:0]], key_on[rk[CW-1:0]]};
    else if (rspl) begin
      if (ra[0]) rd_data = {6'b0, four_op_b[ra[1]], key_on_b[ra[1]]};
      else rd_data = {6'b0, four_op[CW'(NCH-2) + CW'(ra[1])], key_on[CW'(NCH-2) + CW'(ra[1])]};
    end else begin
      case (rg)
        G_TA: rd_data = tmr_load_a;
        G_TB: rd_data = tmr_load_b;
        G_TC: rd_data = {1'b0, tmr_mask, 3'b0, tmr_en};
        G_CF: rd_data = {1'b0, ks_mode, 6'b0};
        G_RH: rd_data = rhythm;
        G_TS: rd_data = test_o;
        G_4O: rd_data = {2'b0, four_op[11:9], four_op[2:0]};
        G_MD: rd_data = {native_mode_i, 6'b0, new_mode_i};
        default: rd_data = 8'h00;
      endcase
    end
  end

  logic wunm;
  assign wunm = wglb && !(wg inside {G_TA, G_TB, G_TC, G_CF, G_RH, G_TS, G_4O});

  assert_clr_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wglb && wg == G_TC && wr_data[7] |=> flag_clr);
  assert_clr_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wglb && wg == G_TC) |=> !flag_clr);
  assert_delay_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_up & delay_dn) == '0);
  assert_bulk_4op_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wglb && wg == G_4O |=> four_op[2:0] == $past(wr_data[2:0]) && four_op[11:9] == $past(wr_data[5:3]));
  assert_test_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wglb && wg == G_TS && wr_data[5] |=> test_o[5] && test_o[0]);
  assert_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wunm |=> $stable(key_on) && $stable(four_op) && $stable(tmr_load_a) && $stable(tmr_load_b)
      && $stable(rhythm) && $stable(test_o) && $stable(ks_mode) && $stable(delay_up));
  assert_key_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(key_on) && $stable(four_op) && $stable(key_on_b));
endmodule

// File: tb/synth_reg_decoder_tb.sv
`timescale 1ns/1ps
module synth_reg_decoder_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0, nm = 0, nat = 0;
  logic [15:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data, tmr_load_a, tmr_load_b, rhythm, test_o;
  logic [17:0] key_on, four_op;
  logic [1:0] key_on_b, four_op_b, tmr_en, tmr_mask;
  logic flag_clr, ks_mode;
  logic [71:0] delay_up, delay_dn;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  synth_reg_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .new_mode_i(nm), .native_mode_i(nat),
    .key_on(key_on), .four_op(four_op), .key_on_b(key_on_b), .four_op_b(four_op_b),
    .tmr_load_a(tmr_load_a), .tmr_load_b(tmr_load_b), .tmr_en(tmr_en), .tmr_mask(tmr_mask),
    .flag_clr(flag_clr), .ks_mode(ks_mode), .rhythm(rhythm), .test_o(test_o),
    .delay_up(delay_up), .delay_dn(delay_dn));

  int m_op [576];
  logic [17:0] m_ko, m_fo;
  logic [1:0] m_kob, m_fob, m_ten, m_tmask;
  logic [71:0] m_up, m_dn;
  logic [7:0] m_ta, m_tb, m_rhy, m_tst;
  logic m_ks, m_clr;

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (rd_addr=%0h)", req, act, exp, rd_addr);
    end
  endtask

  task automatic chk72(string req, logic [71:0] act, logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void m_reset();
    for (int i = 0; i < 576; i++) m_op[i] = (i % 8 == 6) ? 'h30 : 0;
    m_ko = 0; m_fo = 0; m_kob = 0; m_fob = 0; m_ten = 0; m_tmask = 0;
    m_up = 0; m_dn = 0; m_ta = 0; m_tb = 0; m_rhy = 0; m_tst = 0; m_ks = 0; m_clr = 0;
  endfunction

  function automatic void m_write(int a16, int d);
    int a = a16 & 'h7FF;
    int g = a & 'h5FF;
    if (a < 576) begin
      if (a % 8 == 5) begin
        m_up[a/8] = (d >> 5) > (m_op[a] >> 5);
        m_dn[a/8] = (d >> 5) < (m_op[a] >> 5);
      end
      m_op[a] = d;
    end else if (a < 592) begin
      m_ko[a-576] = d[0]; m_fo[a-576] = d[1];
    end else if (a < 596) begin
      int c = (a >> 1) & 1;
      if (a & 1) begin m_kob[c] = d[0]; m_fob[c] = d[1]; end
      else begin m_ko[16+c] = d[0]; m_fo[16+c] = d[1]; end
    end else begin
      case (g)
        'h402: m_ta = d[7:0];
        'h403: m_tb = d[7:0];
        'h404: begin m_ten = d[1:0]; m_tmask = d[6:5]; m_clr = d[7]; end
        'h408: m_ks = d[6];
        'h4BD: m_rhy = d[7:0];
        'h501: m_tst = 8'((d & 'hDE) | ((d >> 5) & 1) | (((d | (d >> 5)) & 1) << 5));
        'h504: begin
          for (int i = 0; i < 3; i++) begin m_fo[i] = d[i]; m_fo[9+i] = d[3+i]; end
        end
        default: ;
      endcase
    end
  endfunction

  function automatic int m_read(int a16);
    int a = a16 & 'h7FF;
    int g = a & 'h5FF;
    if (a < 576) return m_op[a];
    if (a < 592) return m_fo[a-576] * 2 + m_ko[a-576];
    if (a < 596) begin
      int c = (a >> 1) & 1;
      if (a & 1) return m_fob[c] * 2 + m_kob[c];
      return m_fo[16+c] * 2 + m_ko[16+c];
    end
    case (g)
      'h402: return m_ta;
      'h403: return m_tb;
      'h404: return m_ten + m_tmask * 32;
      'h408: return m_ks * 64;
      'h4BD: return m_rhy;
      'h501: return m_tst;
      'h504: return {m_fo[11:9], m_fo[2:0]};
      'h505: return nm + nat * 128;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of(int a16);
    int a = a16 & 'h7FF;
    int g = a & 'h5FF;
    if (a < 576) return ((a % 8) == 5) ? "R5" : "R1";
    if (a < 592) return "R3";
    if (a < 596) return "R4";
    case (g)
      'h402, 'h403, 'h404: return "R6";
      'h408, 'h4BD: return "R8";
      'h501: return "R9";
      'h504: return "R7";
      'h505: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic compare_all();
    chk(req_of(rd_addr), rd_data, m_read(rd_addr));
    chk("R3", key_on, m_ko);
    chk("R7", four_op, m_fo);
    chk("R4", {four_op_b, key_on_b}, {m_fob, m_kob});
    chk("R6", {tmr_load_a, tmr_load_b, tmr_mask, tmr_en}, {m_ta, m_tb, m_tmask, m_ten});
    chk("R6", flag_clr, m_clr);
    chk("R8", {ks_mode, rhythm}, {m_ks, m_rhy});
    chk("R9", test_o, m_tst);
    chk72("R5", delay_up, m_up);
    chk72("R5", delay_dn, m_dn);
  endtask

  task automatic cyc(bit we, int wa, int wd, int ra);
    @(negedge clk);
    wr_en = we; wr_addr = 16'(wa); wr_data = 8'(wd); rd_addr = 16'(ra);
    @(posedge clk);
    m_clr = 0;
    if (we) m_write(wa & 'hFFFF, wd & 'hFF);
    #1 compare_all();
  endtask

  function automatic int pick_addr();
    int hi = $urandom_range(0, 31) << 11;
    int s = $urandom_range(0, 9);
    int glist [12] = '{'h402, 'h403, 'h404, 'h408, 'h4BD, 'h501, 'h504, 'h505, 'h602, 'h400, 'h7FF, 596};
    if (s < 4) return hi | $urandom_range(0, 575);
    if (s == 4) return hi | ($urandom_range(0, 71) * 8 + 5);
    if (s < 7) return hi | $urandom_range(576, 595);
    return hi | glist[$urandom_range(0, 11)];
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R2: reset values, register 6 enables set
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) rd_addr = 16'(i * 72 + (i % 8));
      #1 chk("R2", rd_data, (i % 8 == 6) ? 'h30 : 0);
    end
    @(negedge clk) rd_addr = 16'(575 - 1);
    #1 chk("R2", rd_data, 'h30);
    compare_all();
    // R1: full-byte store, upper address bits dropped
    cyc(1, 'h8000 | 37, 'hA5, 37);
    cyc(1, 575, 'h5A, 'hF800 | 575);
    // R12: same-cycle read shows old value, new after edge
    @(negedge clk);
    wr_en = 1; wr_addr = 16'd100; wr_data = 8'h77; rd_addr = 16'd100;
    #1 chk("R12", rd_data, m_read(100));
    @(posedge clk); m_clr = 0; m_write(100, 'h77);
    #1 chk("R12", rd_data, 'h77);
    // R5: delay up, down, equal
    cyc(1, 13, 'h60, 13);
    cyc(1, 13, 'h20, 13);
    cyc(1, 13, 'h3F, 13);
    // R3 / R4 key-on areas
    cyc(1, 576, 3, 576);
    cyc(1, 591, 2, 591);
    cyc(1, 592, 1, 592);
    cyc(1, 593, 2, 593);
    cyc(1, 594, 3, 594);
    cyc(1, 595, 1, 595);
    // R6 timers and clear pulse
    cyc(1, 'h402, 'hC3, 'h402);
    cyc(1, 'h602, 'h11, 'h403);
    cyc(1, 'h404, 'hFF, 'h404);
    cyc(0, 0, 0, 'h404);
    // R7 / R8 / R9 / R10
    cyc(1, 'h504, 'h3F, 'h504);
    cyc(1, 'h408, 'hFF, 'h408);
    cyc(1, 'h4BD, 'h9C, 'h4BD);
    cyc(1, 'h501, 'h20, 'h501);
    cyc(1, 'h501, 'h01, 'h501);
    cyc(1, 'h501, 'hDE, 'h501);
    nm = 1; nat = 1;
    cyc(1, 'h505, 'hFF, 'h505);
    nm = 0;
    cyc(0, 0, 0, 'h505);
    // R11: unmapped writes ignored and read 0
    cyc(1, 'h400, 'hFF, 'h400);
    cyc(1, 'h7FF, 'hFF, 'h7FF);
    cyc(1, 596, 'hFF, 596);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      if (n % 500 == 0) begin nm = $urandom_range(0, 1); nat = $urandom_range(0, 1); end
      cyc($urandom_range(0, 3) != 0, pick_addr(), $urandom_range(0, 255), pick_addr());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule